// File: doc/BRIEF.md
# Hashed Page Table Hardware Searcher

This block resolves a virtual page number, qualified by a process identifier, into a physical page number by walking a hashed translation table held in physical memory. A hash of the request picks a group of eight consecutive table entries (a slot). The block fetches those entries one per memory read and compares each against the request. If no entry of the first slot matches, a second hash picks another slot, which is searched the same way. The first matching entry ends the walk and its physical page number is returned.

When neither slot holds a match the block answers with a miss. Software then consults the complete backup page table. Only one lookup is in flight at a time. The caller presents requests on a valid/ready port and takes answers on a valid/ready response port. The block drives a simple read port towards memory with one read outstanding at most.

Top module: `hpt_searcher`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0. Once a request is accepted, `req_ready` stays 0 until its response has been taken (`rsp_valid` and `rsp_ready` both 1).
- R2: The first read of a lookup is at word address `tbl_base + P*8`, where the primary slot number P is `req_vpn[5:0] XOR req_pid[5:0]`. Addresses count table entries, so one entry is one address step.
- R3: Inside a slot, entries are read in ascending order: slot base +0, +1, up to +7. A new read is issued only after the previous one has returned.
- R4: Each entry is 45 bits: bit 44 is a valid flag, bits 43:36 the process id, bits 35:16 the virtual page number and bits 15:0 the physical page number. An entry matches only when the valid flag is 1 and both the stored process id and the stored virtual page number equal the request.
- R5: The walk stops at the first matching entry. The response then carries `rsp_hit`=1, the stored physical page number on `rsp_ppn` and, on `rsp_reads`, the number of entries read in total (1 to 16).
- R6: When none of the eight primary entries match, the block searches the secondary slot `S = ~P` (6 bits), starting at `tbl_base + S*8`.
- R7: When neither slot matches, the response carries `rsp_hit`=0, `rsp_ppn`=0 and `rsp_reads`=16.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold their values.
- R9: `mem_rd_en` is a one-cycle pulse per read, and it is never asserted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Word address of the first table entry |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_vpn | input | 20 | Virtual page number to translate |
| req_pid | input | 8 | Process identifier of the request |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_hit | output | 1 | 1 if a matching entry was found |
| rsp_ppn | output | 16 | Physical page number on a hit, 0 on a miss |
| rsp_reads | output | 5 | Entries read during the lookup |
| mem_rd_en | output | 1 | Read strobe towards table memory |
| mem_rd_addr | output | 32 | Word address of the entry to read |
| mem_rd_vld | input | 1 | Read data returned |
| mem_rd_data | input | 45 | Returned table entry |

## Verification
The hardest situations to reach from the ports are the near-misses: an entry that agrees with the request on everything except its valid flag, its process id or its virtual page number. A related case is a hit on the very last entry of the secondary slot, which needs exactly sixteen reads. The stimulus builds the table image in the bench so that each of these decoys sits ahead of the true entry in the primary slot. It also places a match only at the final secondary position. The bench then checks that every read address follows the expected sequence and that the reported read count equals the position of the winning entry. A randomised phase fills slots with decoys and optional matches. During that phase the memory latency and the delay of the response handshake vary.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_ISSUE = 2'd1,
      S_WAIT  = 2'd2,
      S_RESP  = 2'd3
   } hpt_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int PID_W     = 8,
   parameter int SLOT_BITS = 6
) (
   input  logic [SLOT_BITS-1:0] vpn_lo,
   input  logic [PID_W-1:0]     pid,
   output logic [SLOT_BITS-1:0] prim_slot,
   output logic [SLOT_BITS-1:0] sec_slot
);
   logic [SLOT_BITS-1:0] pid_fold;

   generate
      if (PID_W > SLOT_BITS) begin : g_trunc
         assign pid_fold = pid[SLOT_BITS-1:0];
         logic unused_pid_hi;
         assign unused_pid_hi = ^pid[PID_W-1:SLOT_BITS];
      end else if (PID_W == SLOT_BITS) begin : g_same
         assign pid_fold = pid;
      end else begin : g_ext
         assign pid_fold = {{(SLOT_BITS-PID_W){1'b0}}, pid};
      end
   endgenerate

   assign prim_slot = vpn_lo ^ pid_fold;
   assign sec_slot  = ~prim_slot;
endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp #(
   parameter int VPN_W = 20,
   parameter int PID_W = 8,
   parameter int PPN_W = 16,
   localparam int ENT_W = 1 + PID_W + VPN_W + PPN_W
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [VPN_W-1:0] vpn,
   input  logic [PID_W-1:0] pid,
   output logic             match,
   output logic [PPN_W-1:0] ppn
);
   localparam int VPN_LSB = PPN_W;
   localparam int PID_LSB = PPN_W + VPN_W;
   localparam int VLD_BIT = ENT_W - 1;

   logic vpn_eq;
   logic pid_eq;

   assign vpn_eq = (entry[VPN_LSB +: VPN_W] == vpn);
   assign pid_eq = (entry[PID_LSB +: PID_W] == pid);
   assign match  = entry[VLD_BIT] & vpn_eq & pid_eq;
   assign ppn    = entry[PPN_W-1:0];
endmodule

// File: rtl/hpt_searcher.sv
module hpt_searcher #(
   parameter int VPN_W     = 20,
   parameter int PID_W     = 8,
   parameter int PPN_W     = 16,
   parameter int PA_W      = 32,
   parameter int SLOT_BITS = 6,
   parameter int ENTRIES   = 8,
   localparam int ENT_W    = 1 + PID_W + VPN_W + PPN_W,
   localparam int CNT_W    = $clog2(2*ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PA_W-1:0]  tbl_base,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [PID_W-1:0] req_pid,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic             rsp_hit,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic [CNT_W-1:0] rsp_reads,
   output logic             mem_rd_en,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rd_vld,
   input  logic [ENT_W-1:0] mem_rd_data
);
   import hpt_pkg::*;

   localparam int IDX_W    = $clog2(ENTRIES);
   localparam int OFS_W    = SLOT_BITS + IDX_W;
   localparam int LAST_IDX = ENTRIES - 1;
   localparam int ALL_RD   = 2 * ENTRIES;

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two, at least 2");
      end
      if (SLOT_BITS < 1 || SLOT_BITS > VPN_W) begin : g_bad_slots
         $error("SLOT_BITS must lie between 1 and VPN_W");
      end
      if (OFS_W > PA_W) begin : g_bad_pa
         $error("table offset does not fit the address width");
      end
   endgenerate

   hpt_state_e           state_q;
   logic [VPN_W-1:0]     vpn_q;
   logic [PID_W-1:0]     pid_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 pass_q;
   logic [CNT_W-1:0]     reads_q;
   logic                 hit_q;
   logic [PPN_W-1:0]     ppn_q;

   logic [SLOT_BITS-1:0] prim_slot;
   logic [SLOT_BITS-1:0] sec_slot;
   logic [SLOT_BITS-1:0] cur_slot;
   logic                 ent_match;
   logic [PPN_W-1:0]     ent_ppn;

   hpt_hash #(
      .PID_W    (PID_W),
      .SLOT_BITS(SLOT_BITS)
   ) u_hash (
      .vpn_lo   (vpn_q[SLOT_BITS-1:0]),
      .pid      (pid_q),
      .prim_slot(prim_slot),
      .sec_slot (sec_slot)
   );

   hpt_entry_cmp #(
      .VPN_W(VPN_W),
      .PID_W(PID_W),
      .PPN_W(PPN_W)
   ) u_cmp (
      .entry(mem_rd_data),
      .vpn  (vpn_q),
      .pid  (pid_q),
      .match(ent_match),
      .ppn  (ent_ppn)
   );

   assign cur_slot    = pass_q ? sec_slot : prim_slot;
   assign mem_rd_addr = tbl_base + PA_W'({cur_slot, idx_q});
   assign mem_rd_en   = (state_q == S_ISSUE);
   assign req_ready   = (state_q == S_IDLE);
   assign rsp_valid   = (state_q == S_RESP);
   assign rsp_hit     = hit_q;
   assign rsp_ppn     = ppn_q;
   assign rsp_reads   = reads_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         vpn_q   <= '0;
         pid_q   <= '0;
         idx_q   <= '0;
         pass_q  <= 1'b0;
         reads_q <= '0;
         hit_q   <= 1'b0;
         ppn_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  vpn_q   <= req_vpn;
                  pid_q   <= req_pid;
                  idx_q   <= '0;
                  pass_q  <= 1'b0;
                  reads_q <= '0;
                  hit_q   <= 1'b0;
                  ppn_q   <= '0;
                  state_q <= S_ISSUE;
               end
            end
            S_ISSUE: state_q <= S_WAIT;
            S_WAIT: begin
               if (mem_rd_vld) begin
                  reads_q <= reads_q + 1'b1;
                  if (ent_match) begin
                     hit_q   <= 1'b1;
                     ppn_q   <= ent_ppn;
                     state_q <= S_RESP;
                  end else if (idx_q == IDX_W'(LAST_IDX)) begin
                     if (!pass_q) begin
                        pass_q  <= 1'b1;
                        idx_q   <= '0;
                        state_q <= S_ISSUE;
                     end else begin
                        hit_q   <= 1'b0;
                        ppn_q   <= '0;
                        state_q <= S_RESP;
                     end
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= S_ISSUE;
                  end
               end
            end
            S_RESP: begin
               if (rsp_ready) state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R1: an accepted request closes the request port and no answer is immediate
   p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !rsp_valid);

   // R9: read strobe is a single-cycle pulse
   p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R8: pending response keeps its contents
   p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_ppn)
                                  && $stable(rsp_reads));

   // R7: a miss always follows a full search of both slots
   p_miss_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_reads == CNT_W'(ALL_RD) && rsp_ppn == '0);

   // R5: the read count of any answer lies within the two slots
   p_reads_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_reads != '0 && rsp_reads <= CNT_W'(ALL_RD));

   // R1: response port and request port are never open together
   p_ports_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && req_ready));
endmodule

// File: tb/hpt_searcher_bench.sv
module hpt_searcher_bench;
   localparam logic [31:0] BASE = 32'h1000_0000;

   typedef struct {
      bit        hit;
      bit [15:0] ppn;
      int        reads;
      int        stall;
      string     tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_vpn = '0;
   logic [7:0]  req_pid = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic        rsp_hit;
   logic [15:0] rsp_ppn;
   logic [4:0]  rsp_reads;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_vld = 1'b0;
   logic [44:0] mem_rd_data = '0;

   logic [44:0] tbl [0:511];
   item_t       exp_q[$];
   logic [31:0] addr_q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   hpt_searcher u_hpt_searcher (
      .clk(clk), .rst_n(rst_n), .tbl_base(BASE),
      .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_pid(req_pid),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
      .rsp_reads(rsp_reads), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [44:0] mk(input bit v, input logic [7:0] pid,
                                      input logic [19:0] vpn, input logic [15:0] ppn);
      return {v, pid, vpn, ppn};
   endfunction

   function automatic int slot_of(input logic [19:0] vpn, input logic [7:0] pid, input bit second);
      logic [5:0] s;
      s = vpn[5:0] ^ pid[5:0];
      if (second) s = ~s;
      return int'(s);
   endfunction

   task automatic clear_tbl();
      for (int i = 0; i < 512; i++) tbl[i] = '0;
   endtask

   // driver: predicts addresses and result, then issues the request
   task automatic lookup(input logic [19:0] vpn, input logic [7:0] pid,
                         input int stall, input string tag);
      item_t it;
      logic [44:0] e;
      int idx;
      it.hit = 1'b0; it.ppn = '0; it.reads = 0; it.stall = stall; it.tag = tag;
      for (int p = 0; p < 2; p++) begin
         for (int k = 0; k < 8; k++) begin
            if (!it.hit) begin
               idx = slot_of(vpn, pid, p == 1) * 8 + k;
               addr_q.push_back(BASE + 32'(idx));
               it.reads++;
               e = tbl[idx];
               if (e[44] && e[43:36] == pid && e[35:16] == vpn) begin
                  it.hit = 1'b1;
                  it.ppn = e[15:0];
               end
            end
         end
      end
      exp_q.push_back(it);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vpn = vpn; req_pid = pid;
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // memory responder: checks each read address, returns data after 1..3 cycles
   initial begin
      logic [31:0] ea;
      logic [44:0] d;
      int lat;
      @(negedge clk);
      forever begin
         if (mem_rd_en) begin
            if (addr_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected read", mem_rd_addr, 0);
               ea = mem_rd_addr;
            end else begin
               ea = addr_q.pop_front();
               chk(mem_rd_addr == ea, "R2 R3 R6", "read address", mem_rd_addr, ea);
            end
            d = tbl[(mem_rd_addr - BASE) & 32'h1FF];
            lat = 1 + int'($urandom % 3);
            repeat (lat) @(negedge clk);
            chk(!mem_rd_en, "R9", "read strobe while waiting", mem_rd_en, 0);
            mem_rd_vld = 1'b1; mem_rd_data = d;
            @(negedge clk);
            mem_rd_vld = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   // monitor: compares responses with the scoreboard, holds off rsp_ready as asked
   initial begin
      int wait_left;
      item_t it;
      wait_left = -1;
      forever begin
         @(negedge clk);
         if (rsp_ready) begin
            void'(exp_q.pop_front());
            rsp_ready = 1'b0;
            wait_left = -1;
         end else if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1", "response without request", rsp_valid, 0);
            end else begin
               it = exp_q[0];
               if (wait_left < 0) wait_left = it.stall;
               chk(rsp_hit == it.hit, it.tag, "hit", rsp_hit, it.hit);
               chk(rsp_ppn == it.ppn, it.tag, "ppn", rsp_ppn, it.ppn);
               chk(int'(rsp_reads) == it.reads, it.tag, "reads", rsp_reads, it.reads);
               chk(!req_ready, "R1", "req_ready while answering", req_ready, 0);
               if (wait_left > 0) wait_left--;
               else rsp_ready = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [19:0] v;
      logic [7:0]  pd;
      int s, k;
      clear_tbl();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
      chk(mem_rd_en == 1'b0, "R1", "reset mem_rd_en", mem_rd_en, 0);

      // R7: empty table, both slots walked
      lookup(20'h12345, 8'h07, 0, "R7");

      // R5: hit at first primary entry
      v = 20'h0ABCD; pd = 8'h21;
      tbl[slot_of(v, pd, 0)*8] = mk(1, pd, v, 16'hBEEF);
      lookup(v, pd, 0, "R5");

      // R4: decoys before the true entry
      clear_tbl();
      v = 20'h3C0F1; pd = 8'h5A;
      s = slot_of(v, pd, 0) * 8;
      tbl[s+0] = mk(0, pd, v, 16'h1111);
      tbl[s+1] = mk(1, pd ^ 8'h80, v, 16'h2222);
      tbl[s+2] = mk(1, pd, v ^ 20'h10000, 16'h3333);
      tbl[s+3] = mk(1, pd, v, 16'h4444);
      lookup(v, pd, 0, "R4");

      // R5: two matches, first one wins
      clear_tbl();
      v = 20'h00777; pd = 8'h13;
      s = slot_of(v, pd, 0) * 8;
      tbl[s+2] = mk(1, pd, v, 16'hAAAA);
      tbl[s+6] = mk(1, pd, v, 16'h5555);
      lookup(v, pd, 0, "R5");

      // R6: only match at last secondary entry
      clear_tbl();
      v = 20'hFFF00; pd = 8'h3F;
      tbl[slot_of(v, pd, 1)*8 + 7] = mk(1, pd, v, 16'hC0DE);
      lookup(v, pd, 0, "R6");

      // R8: response held under back-pressure
      lookup(v, pd, 5, "R8");

      // R2: high process-id bits do not enter the hash
      clear_tbl();
      v = 20'h00015; pd = 8'hC0;
      tbl[slot_of(v, pd, 0)*8 + 4] = mk(1, pd, v, 16'h0F0F);
      lookup(v, pd, 2, "R2");

      // randomised lookups with decoys
      for (int n = 0; n < 40; n++) begin
         clear_tbl();
         v = 20'($urandom); pd = 8'($urandom);
         for (int j = 0; j < 6; j++) begin
            s = slot_of(v, pd, ($urandom % 2) == 1) * 8 + int'($urandom % 8);
            tbl[s] = mk(1'($urandom), pd ^ 8'($urandom % 2), v ^ 20'($urandom % 2), 16'($urandom));
         end
         if ($urandom % 4 != 0) begin
            s = slot_of(v, pd, ($urandom % 2) == 1) * 8;
            k = int'($urandom % 8);
            tbl[s+k] = mk(1, pd, v, 16'($urandom));
         end
         lookup(v, pd, int'($urandom % 4), "R5 R6");
      end

      repeat (5) @(negedge clk);
      chk(addr_q.size() == 0, "R3", "reads left unissued", addr_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule